// File: doc/BRIEF.md
# Serial Stream Receiver with Programmable Input Skew

This block turns one serial time-division line into parallel channel bytes. The line runs at half the master clock rate, so every bit cell spans two master-clock periods. A frame holds 32 channels of 8 bits. A frame pulse marks the start of each frame, and the receiver emits each recovered byte with its channel index and a one-cycle strobe.

Two line formats are supported. In the first format, cells start on falling edges and channels are sent most significant bit first. In the second format, cells start on rising edges and channels are sent least significant bit first. The sampling point of the line can be delayed to absorb backplane skew. The delay is set in whole clock periods, with an extra half period available, and reaches at most four and a half periods.

Format and skew are plain inputs. The receiver captures them on every frame pulse, so they stay fixed for the whole frame.

Top module: `serial_skew_rx`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `byte_valid`, `byte_data` and `byte_chan` are all zero.
- R2: With `gci_mode`=0 and `skew_cfg`=0, the following timing holds. Let the posedge at which `frame_pulse` is seen high be half-period position 0. Bit cell b then starts at position 4b+1 and is sampled at position 4b+4, a rising edge. Channel c's byte arrives most significant bit first and is output unchanged with `byte_chan`=c.
- R3: With `gci_mode`=1, bit cell b starts at position 4b and is sampled at position 4b+3 with zero skew, a falling edge. Bits arrive least significant first, and the output byte is reassembled with the first-arrived bit at bit 0.
- R4: `skew_cfg`[3:1] gives a whole-clock delay w. The sampling point moves later by 2w half periods. Format and skew are captured on each frame pulse and hold for that frame.
- R5: `skew_cfg`[0]=1 moves the sampling point one further half period later, onto the opposite clock edge, for a total reach of 4.5 periods.
- R6: Each frame gives exactly 32 one-cycle strobes, one per channel, in ascending index order. The strobe for a channel rises one cycle after the posedge that handles that channel's eighth bit. No strobe appears outside a frame.
- R7: Whole-clock codes 5, 6 and 7 act as a delay of 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, twice the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| frame_pulse | input | 1 | Frame start, seen high on one posedge |
| rx_line | input | 1 | Serial input line |
| gci_mode | input | 1 | 0: falling-edge cells, MSB first; 1: rising-edge cells, LSB first |
| skew_cfg | input | 4 | {whole-clock delay[2:0], half-clock bit} |
| byte_valid | output | 1 | One-cycle strobe for a recovered byte |
| byte_data | output | 8 | Recovered byte, bit 7 is the MSB |
| byte_chan | output | 5 | Channel index of the byte |

## Verification
The bench drives two frames for every combination of the two formats and the 16 skew codes. This covers the odd sampling points that can only be read from the negative-edge capture register, so a design that picks the wrong edge returns the neighbouring half-cell and corrupts bytes.

The last cells of a frame are sampled after the next frame pulse has already arrived. A receiver that restarted its sample counter on the raw pulse would therefore lose or duplicate channel 31.

The bench flags several other faults:
- A byte left in arrival order for the least-significant-first format shows up reversed.
- Skew codes above four that are not clamped lose whole bits.
- Any shift in strobe position shows up as a missing or misplaced strobe on a compared clock.

// File: rtl/sr_rx_pkg.sv
package sr_rx_pkg;
  typedef enum logic {FMT_FALL = 1'b0, FMT_RISE = 1'b1} line_fmt_e;
endpackage

// File: rtl/sr_frame_align.sv
module sr_frame_align #(
  parameter int OFS_W     = 3,
  parameter int MAX_WHOLE = 4,
  parameter int TAP_N     = 7
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    fp_in,
  input  sr_rx_pkg::line_fmt_e    fmt_in,
  input  logic [OFS_W:0]          skew_in,
  output logic                    start,
  output logic                    start_neg,
  output sr_rx_pkg::line_fmt_e    start_fmt
);
  import sr_rx_pkg::*;
  localparam int QW = 6;
  localparam int TW = $clog2(TAP_N);

  logic [TAP_N-1:0] fp_sr;
  line_fmt_e        fmt_q;
  logic [OFS_W:0]   skew_q;
  logic [OFS_W-1:0] whole_c;
  logic [QW-1:0]    q_c, k0_c;
  logic [TW-1:0]    tap_c;

  // sample position in half periods after the frame edge: start offset + 3/4 cell + skew
  always_comb begin
    whole_c = (skew_q[OFS_W:1] > OFS_W'(MAX_WHOLE)) ? OFS_W'(MAX_WHOLE) : skew_q[OFS_W:1];
    q_c     = QW'((fmt_q == FMT_RISE) ? 0 : 1) + QW'(3) + QW'({whole_c, 1'b0}) + QW'(skew_q[0]);
    k0_c    = (q_c + QW'(1)) >> 1;
    tap_c   = TW'(k0_c - QW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fp_sr  <= '0;
      fmt_q  <= FMT_FALL;
      skew_q <= '0;
    end else begin
      fp_sr <= {fp_sr[TAP_N-2:0], fp_in};
      if (fp_in) begin
        fmt_q  <= fmt_in;
        skew_q <= skew_in;
      end
    end
  end

  assign start     = fp_sr[tap_c];
  assign start_neg = q_c[0];
  assign start_fmt = fmt_q;
endmodule

// File: rtl/sr_edge_capture.sv
module sr_edge_capture (
  input  logic clk,
  input  logic rx,
  input  logic use_neg,
  output logic bit_o
);
  logic rx_n;

  always_ff @(negedge clk) rx_n <= rx;

  assign bit_o = use_neg ? rx_n : rx;
endmodule

// File: rtl/sr_byte_build.sv
module sr_byte_build #(
  parameter int CHANNELS = 32,
  parameter int BITS     = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic                          start_neg,
  input  sr_rx_pkg::line_fmt_e          start_fmt,
  input  logic                          sample_bit,
  output logic                          sel_neg,
  output logic                          out_valid,
  output logic [BITS-1:0]               out_data,
  output logic [$clog2(CHANNELS)-1:0]   out_chan
);
  import sr_rx_pkg::*;
  localparam int TOTAL = CHANNELS * BITS;
  localparam int IW    = $clog2(TOTAL);
  localparam int BW    = $clog2(BITS);
  localparam int CW    = $clog2(CHANNELS);
  localparam logic [IW-1:0] LAST = IW'(TOTAL - 1);

  logic            run, tgl, neg_q, shift_en;
  line_fmt_e       fmt_q, fmt_eff;
  logic [IW-1:0]   bit_idx, cur_idx;
  logic [BITS-2:0] sh;
  logic [BITS-1:0] arrival, rev, byte_c;

  always_comb begin
    shift_en = start || (run && !tgl);
    cur_idx  = start ? '0 : bit_idx;
    fmt_eff  = start ? start_fmt : fmt_q;
    sel_neg  = start ? start_neg : neg_q;
    arrival  = {sh, sample_bit};
    byte_c   = (fmt_eff == FMT_RISE) ? rev : arrival;
  end

  for (genvar i = 0; i < BITS; i++) begin : g_rev
    assign rev[i] = arrival[BITS-1-i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0; tgl <= 1'b0; neg_q <= 1'b0; fmt_q <= FMT_FALL;
      bit_idx <= '0; sh <= '0;
      out_valid <= 1'b0; out_data <= '0; out_chan <= '0;
    end else begin
      out_valid <= 1'b0;
      if (start) begin
        run <= 1'b1; tgl <= 1'b1; bit_idx <= IW'(1);
        neg_q <= start_neg; fmt_q <= start_fmt;
      end else if (run) begin
        if (tgl) tgl <= 1'b0;
        else begin
          tgl     <= 1'b1;
          bit_idx <= bit_idx + IW'(1);
          if (bit_idx == LAST) run <= 1'b0;
        end
      end
      if (shift_en) begin
        sh <= arrival[BITS-2:0];
        if (cur_idx[BW-1:0] == BW'(BITS - 1)) begin
          out_valid <= 1'b1;
          out_data  <= byte_c;
          out_chan  <= cur_idx[IW-1:BW];
        end
      end
    end
  end

  // R6: a strobe never lasts two cycles
  p_single_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  // R6: the last channel's strobe coincides with the end of sampling
  p_last_chan_stop_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_chan == CW'(CHANNELS - 1)) |-> !run);
  // R6: sampling keeps running until the final cell of the frame
  p_run_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (run && !start && bit_idx != LAST) |=> run);
endmodule

// File: rtl/serial_skew_rx.sv
module serial_skew_rx #(
  parameter int CHANNELS  = 32,
  parameter int BITS      = 8,
  parameter int OFS_W     = 3,
  parameter int MAX_WHOLE = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        frame_pulse,
  input  logic                        rx_line,
  input  logic                        gci_mode,
  input  logic [OFS_W:0]              skew_cfg,
  output logic                        byte_valid,
  output logic [BITS-1:0]             byte_data,
  output logic [$clog2(CHANNELS)-1:0] byte_chan
);
  import sr_rx_pkg::*;
  localparam int TAP_N = (1 + 3 + 2 * MAX_WHOLE + 1 + 1) / 2;

  logic      start, start_neg, sel_neg, sample_bit;
  line_fmt_e start_fmt;

  sr_frame_align #(.OFS_W(OFS_W), .MAX_WHOLE(MAX_WHOLE), .TAP_N(TAP_N)) u_align (
    .clk(clk), .rst(rst), .fp_in(frame_pulse),
    .fmt_in(gci_mode ? FMT_RISE : FMT_FALL), .skew_in(skew_cfg),
    .start(start), .start_neg(start_neg), .start_fmt(start_fmt));

  sr_edge_capture u_cap (
    .clk(clk), .rx(rx_line), .use_neg(sel_neg), .bit_o(sample_bit));

  sr_byte_build #(.CHANNELS(CHANNELS), .BITS(BITS)) u_build (
    .clk(clk), .rst(rst), .start(start), .start_neg(start_neg),
    .start_fmt(start_fmt), .sample_bit(sample_bit), .sel_neg(sel_neg),
    .out_valid(byte_valid), .out_data(byte_data), .out_chan(byte_chan));

  // R1: outputs are idle right after a reset cycle
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!byte_valid && byte_data == '0 && byte_chan == '0));
endmodule

// File: tb/sim_serial_skew_rx.sv
module sim_serial_skew_rx;
  logic clk = 1'b0, rst = 1'b1, frame_pulse = 1'b0, rx_line = 1'b1, gci_mode = 1'b0;
  logic [3:0] skew_cfg = 4'd0;
  logic       byte_valid;
  logic [7:0] byte_data;
  logic [4:0] byte_chan;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  serial_skew_rx u0 (.clk(clk), .rst(rst), .frame_pulse(frame_pulse), .rx_line(rx_line),
    .gci_mode(gci_mode), .skew_cfg(skew_cfg), .byte_valid(byte_valid),
    .byte_data(byte_data), .byte_chan(byte_chan));

  localparam int NFR = 2;

  function automatic int pat(int f, int ch, int seed);
    return (ch * 29 + f * 71 + seed * 17 + 90) & 255;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_cfg(bit gci, int code);
    int whole, d, s0, k0, tend;
    string tag;
    whole = ((code >> 1) > 4) ? 4 : (code >> 1);
    d  = 2 * whole + (code & 1);
    s0 = gci ? 0 : 1;
    k0 = (s0 + 3 + d + 1) / 2;
    tend = NFR * 1024 + 60;
    if ((code >> 1) > 4) tag = "R7";
    else if (code & 1) tag = "R5";
    else if ((code >> 1) > 0) tag = "R4";
    else if (gci) tag = "R3";
    else tag = "R2";
    gci_mode = gci; skew_cfg = 4'(code);
    @(posedge clk);
    for (int t = -2; t < tend; t++) begin
      int u, bg, f, b, v, k, r;
      bit ev;
      if (t > -2) @(clk);
      #1;
      frame_pulse = 1'b0;
      for (int fi = 0; fi < NFR; fi++)
        if (t - fi * 1024 == -2 || t - fi * 1024 == -1) frame_pulse = 1'b1;
      u = t - s0 - d;
      v = 1;
      if (u >= 0) begin
        bg = u / 4; f = bg / 256; b = bg % 256;
        if (f < NFR) v = (pat(f, b / 8, code + 16 * gci) >> (gci ? (b % 8) : (7 - b % 8))) & 1;
      end
      rx_line = 1'(v);
      if (t >= 1 && (t % 2) == 1) begin
        k = (t - 1) / 2;
        r = k - k0;
        ev = (r >= 0) && (r % 2 == 0) && (r / 512 < NFR) && (((r % 512) / 2) % 8 == 7);
        chk(byte_valid == ev, "R6", int'(byte_valid), int'(ev));
        if (ev && byte_valid) begin
          f = r / 512; b = (r % 512) / 2;
          chk(byte_chan == 5'(b / 8), "R6", int'(byte_chan), b / 8);
          chk(byte_data == 8'(pat(f, b / 8, code + 16 * gci)), tag, int'(byte_data),
              pat(f, b / 8, code + 16 * gci));
        end
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(!byte_valid && byte_data == 0 && byte_chan == 0, "R1", int'(byte_data), 0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk); #1;
    chk(!byte_valid && byte_data == 0 && byte_chan == 0, "R1", int'(byte_valid), 0);
    for (int g = 0; g < 2; g++)
      for (int c = 0; c < 16; c++) run_cfg(1'(g), c);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(150000 * 10);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule